// File: doc/BRIEF.md
# Hobby Servo Pulse Generator

This block drives the control line of a hobby servo from a 50 MHz system clock. It repeats a fixed frame near 50 Hz. Each frame opens with a high pulse, and the pulse length sets the servo angle. A prescaler turns the system clock into a slow tick. A tick counter steps through the frame and ends the pulse when it reaches the registered pulse width.

The position command is an unsigned number of ticks. The block clamps it to the servo's calibrated travel window and loads it only at a frame boundary, so a pulse already on the wire is never cut short or stretched. With the default parameters the tick is 1 us and the frame is 20 000 ticks (50 Hz). The window then runs from 840 ticks (4.2 %, full counter-clockwise) to 1960 ticks (9.8 %, full clockwise). Reset loads 1400 ticks (7.0 %, centre).

Top module: `servo_pwm`

## Requirements
- R1: The output repeats with a period of exactly PRESCALE × FRAME_TICKS clock cycles. The defaults (50 cycles × 20 000 ticks at 50 MHz) give 50 Hz, which lies inside the 45–55 Hz band.
- R2: A command W with MIN_TICKS ≤ W ≤ MAX_TICKS gives a high time of exactly W × PRESCALE cycles per frame.
- R3: A command below MIN_TICKS gives a MIN_TICKS pulse, and a command above MAX_TICKS gives a MAX_TICKS pulse. The limit values themselves pass through unchanged.
- R4: Each frame has exactly one pulse, and it starts at the first clock of the frame, when the tick count is 0.
- R5: The command is sampled only on the clock edge that starts a new frame. A change during a frame has no effect on that frame's pulse and takes effect in the next frame.
- R6: While reset is asserted, the tick count is 0, the pulse width is CENTER_TICKS and the output is high. The first frame after reset carries a CENTER_TICKS pulse whatever the command is.
- R7: `pos_cmd` is read as an unsigned binary count of ticks, with bit 0 as the least significant bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (50 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| pos_cmd | input | CMD_W | Requested pulse width in ticks, unsigned |
| pwm_out | output | 1 | Servo control pulse train |

## Verification
The hardest case to reach from the ports is a command that changes while a pulse is already high. The stimulus has to land inside that one pulse and not in the low tail of the frame. The bench waits for a rising edge of the output and counts a few high samples. It then swaps the command and keeps counting until the output falls. It checks that the whole pulse still matches the old width, and that the following frame matches the new one. The frame is shortened through parameters so that the clamp cases, both exact limits and the reset frame can all be measured edge to edge.

// File: rtl/servo_pwm.sv
module servo_pwm #(
  parameter int PRESCALE     = 50,
  parameter int FRAME_TICKS  = 20000,
  parameter int MIN_TICKS    = 840,
  parameter int MAX_TICKS    = 1960,
  parameter int CENTER_TICKS = 1400,
  parameter int CMD_W        = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CMD_W-1:0] pos_cmd,
  output logic             pwm_out
);
  localparam int PRE_W  = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int TICK_W = $clog2(FRAME_TICKS);
  localparam logic [CMD_W-1:0]  CMD_LO   = CMD_W'(MIN_TICKS);
  localparam logic [CMD_W-1:0]  CMD_HI   = CMD_W'(MAX_TICKS);
  localparam logic [TICK_W-1:0] TICK_LO  = TICK_W'(MIN_TICKS);
  localparam logic [TICK_W-1:0] TICK_HI  = TICK_W'(MAX_TICKS);
  localparam logic [TICK_W-1:0] TICK_MID = TICK_W'(CENTER_TICKS);
  localparam logic [TICK_W-1:0] TICK_END = TICK_W'(FRAME_TICKS - 1);

  logic              tick;
  logic [TICK_W-1:0] tick_cnt;
  logic [TICK_W-1:0] width_q;
  logic [TICK_W-1:0] width_d;
  logic              frame_end;

  generate
    if (PRESCALE > 1) begin : g_div
      localparam logic [PRE_W-1:0] PRE_END = PRE_W'(PRESCALE - 1);
      logic [PRE_W-1:0] pre_cnt;
      always_ff @(posedge clk) begin
        if (!rst_n || pre_cnt == PRE_END) pre_cnt <= '0;
        else                              pre_cnt <= pre_cnt + 1'b1;
      end
      assign tick = (pre_cnt == PRE_END);
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate

  assign frame_end = tick && (tick_cnt == TICK_END);

  always_comb begin
    if (pos_cmd < CMD_LO)      width_d = TICK_LO;
    else if (pos_cmd > CMD_HI) width_d = TICK_HI;
    else                       width_d = TICK_W'(pos_cmd);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_cnt <= '0;
      width_q  <= TICK_MID;
    end else if (frame_end) begin
      tick_cnt <= '0;
      width_q  <= width_d;
    end else if (tick) begin
      tick_cnt <= tick_cnt + 1'b1;
    end
  end

  assign pwm_out = (tick_cnt < width_q);
endmodule

// File: rtl/servo_pwm_chk.sv
module servo_pwm_chk #(
  parameter int FRAME_TICKS  = 20000,
  parameter int MIN_TICKS    = 840,
  parameter int MAX_TICKS    = 1960,
  parameter int CENTER_TICKS = 1400,
  parameter int TICK_W       = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwm_out,
  input logic [TICK_W-1:0] tick_cnt,
  input logic [TICK_W-1:0] width_q
);
  assert_tick_in_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tick_cnt) < FRAME_TICKS);

  assert_fall_at_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwm_out) |-> tick_cnt == width_q);

  assert_width_clamped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(width_q) >= MIN_TICKS && int'(width_q) <= MAX_TICKS);

  assert_rise_at_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_out) |-> tick_cnt == '0);

  assert_width_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_cnt != '0) |-> $stable(width_q));

  assert_reset_centre_R6: assert property (@(posedge clk)
    !rst_n |=> (int'(width_q) == CENTER_TICKS && tick_cnt == '0));
endmodule

bind servo_pwm servo_pwm_chk #(
  .FRAME_TICKS(FRAME_TICKS), .MIN_TICKS(MIN_TICKS), .MAX_TICKS(MAX_TICKS),
  .CENTER_TICKS(CENTER_TICKS), .TICK_W(TICK_W)
) chk (
  .clk(clk), .rst_n(rst_n), .pwm_out(pwm_out),
  .tick_cnt(tick_cnt), .width_q(width_q)
);

// File: tb/servo_pwm_test.sv
module servo_pwm_test;
  localparam int P   = 2;
  localparam int FT  = 500;
  localparam int MN  = 21;
  localparam int MX  = 49;
  localparam int CT  = 35;
  localparam int CW  = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] pos_cmd = '0;
  logic          pwm_out;
  int            n_chk = 0;
  int            n_bad = 0;
  bit            done = 1'b0;

  servo_pwm #(.PRESCALE(P), .FRAME_TICKS(FT), .MIN_TICKS(MN), .MAX_TICKS(MX),
              .CENTER_TICKS(CT), .CMD_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .pos_cmd(pos_cmd), .pwm_out(pwm_out));

  always #5 clk = ~clk;

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic wait_rise();
    logic p;
    p = pwm_out;
    forever begin
      @(negedge clk);
      if (!p && pwm_out) break;
      p = pwm_out;
    end
  endtask

  task automatic count_frame(output int hi, output int per);
    int lo;
    hi = 0; lo = 0;
    while (pwm_out)  begin hi++; @(negedge clk); end
    while (!pwm_out) begin lo++; @(negedge clk); end
    per = hi + lo;
  endtask

  task automatic t_reset();
    int hi, per;
    rst_n = 1'b0;
    pos_cmd = CW'(MX);
    repeat (3) @(negedge clk);
    check("R6 output high in reset", int'(pwm_out), 1);
    rst_n = 1'b1;
    count_frame(hi, per);
    check("R6 first frame centre width", hi, CT * P);
    check("R1 first frame period", per, FT * P);
  endtask

  task automatic t_width(input string tag, input int cmd, input int exp_ticks);
    int hi, per;
    @(negedge clk);
    pos_cmd = CW'(cmd);
    wait_rise();
    count_frame(hi, per);
    check(tag, hi, exp_ticks * P);
    check("R1 frame period", per, FT * P);
  endtask

  task automatic t_midframe();
    int hi, per, k;
    @(negedge clk);
    pos_cmd = CW'(MN + 3);
    wait_rise();
    k = 0;
    while (pwm_out && k < 5) begin k++; @(negedge clk); end
    pos_cmd = CW'(MX - 2);
    while (pwm_out) begin k++; @(negedge clk); end
    check("R5 pulse in flight keeps old width", k, (MN + 3) * P);
    wait_rise();
    count_frame(hi, per);
    check("R5 new width in next frame", hi, (MX - 2) * P);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_width("R2 mid command", 30, 30);
    t_width("R2 centre command", CT, CT);
    t_width("R3 exact minimum", MN, MN);
    t_width("R3 exact maximum", MX, MX);
    t_width("R3 one below minimum", MN - 1, MN);
    t_width("R3 zero clamps to minimum", 0, MN);
    t_width("R3 one above maximum", MX + 1, MX);
    t_width("R7 all ones clamps to maximum", (1 << CW) - 1, MX);
    t_width("R7 unsigned bit weights", 'h24, 36);
    t_midframe();
    t_width("R4 single pulse after change", 40, 40);
    t_reset();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule